// File: doc/BRIEF.md
# External Memory Access Sequencer

This block sits between a processor core and one shared external memory bus. In a single instruction cycle the core can raise up to three external requests: an X-data access, a Y-data access and a program fetch. The bus has one 16-bit address path and one 24-bit data path, so the block queues the requests and places them on the bus one after another. It holds the core stalled until the last access completes.

Each access runs as a bus slot. The slot starts with one setup cycle, in which the address and the space selects are driven and both strobes are inactive. A strobe phase follows, lasting one clock plus a per-space number of wait states. Three select outputs work as extra address lines and divide the external range into program, X and Y spaces. In a debug mode, a fetch from the low vector area is flagged by pulling the X/Y line low. When the core makes no external request, the address and select lines keep their last values, so they do not switch without need.

To start a set of requests, the core pulses `req_load` with its request flags while `stall` is low. Read data is collected into per-space result registers. Write data is driven, with its output enable, only during the write strobe.

Top module: `xmem_access_seq`

## Requirements
- R1: A `req_load` accepted with `stall` low and at least one request raises `stall` from the next cycle. `stall` then stays high for exactly the sum of (wait states + 2) over the requested spaces. A `req_load` with no request leaves `stall` low.
- R2: Pending accesses are served strictly in the order X, then Y, then program. Absent spaces are skipped.
- R3: The select outputs use this encoding. Program: `ps_n`=0, `ds_n`=1, `xy_sel`=1. X: `ps_n`=1, `ds_n`=0, `xy_sel`=1. Y: `ps_n`=1, `ds_n`=0, `xy_sel`=0. `ps_n` and `ds_n` are never low together.
- R4: With `dev_mode`=1 at load, a program fetch from an address below `VEC_WORDS` (default 128) drives `xy_sel` low while `ps_n` is low. Otherwise a program fetch keeps `xy_sel` high.
- R5: `rd_n` and `wr_n` are never low together. Every strobe is preceded by a setup cycle with both strobes high, so a read strobe never turns directly into a write strobe.
- R6: Each access holds its strobe low for 1 + `ws_<space>` clocks. `ws_x`, `ws_y` and `ws_p` are 4-bit inputs.
- R7: While no access is in progress, `ext_addr`, `ps_n`, `ds_n` and `xy_sel` keep the values of the last access, whatever the request inputs do.
- R8: A read captures `ext_din`, as seen in the last strobe cycle, into that space's result register. A write drives its data on `ext_dout` with `ext_doe`=1 during its strobe.
- R9: After reset, `stall`=0, `rd_n`=`wr_n`=1, `ps_n`=`ds_n`=1 and `ext_doe`=0. A combined X+Y request takes two separate bus slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_load | input | 1 | Core presents a request set this cycle |
| x_req | input | 1 | X-data access requested |
| x_we | input | 1 | X access is a write |
| x_addr | input | 16 | X address |
| x_wdata | input | 24 | X write data |
| y_req | input | 1 | Y-data access requested |
| y_we | input | 1 | Y access is a write |
| y_addr | input | 16 | Y address |
| y_wdata | input | 24 | Y write data |
| p_req | input | 1 | Program fetch requested |
| p_addr | input | 16 | Program address |
| dev_mode | input | 1 | Debug mode: flag vector fetches on xy_sel |
| ws_x | input | 4 | Wait states for X accesses |
| ws_y | input | 4 | Wait states for Y accesses |
| ws_p | input | 4 | Wait states for program fetches |
| ext_din | input | 24 | Data from external memory |
| stall | output | 1 | Core must hold while high |
| ext_addr | output | 16 | External address |
| ext_dout | output | 24 | Data to external memory |
| ext_doe | output | 1 | Data output enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ps_n | output | 1 | Program space select, active low |
| ds_n | output | 1 | Data space select, active low |
| xy_sel | output | 1 | 1 = X space, 0 = Y space or flagged vector fetch |
| x_rdata | output | 24 | Last X read result |
| y_rdata | output | 24 | Last Y read result |
| p_rdata | output | 24 | Last program read result |

## Verification
Some properties are checked by assertions on every cycle: strobe exclusivity, a setup cycle before each strobe, the two space selects never active together, the service order never moving back toward X within a set, and address and selects frozen while idle. Other behaviour can only be shown by the bench's directed scenarios: the exact stall length for given wait states, the strobe length per space, read capture and write data, and the vector flag in debug mode. These need known stimulus and computed expected values.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

  localparam int NSPACE = 3;  // request bit order: [0]=X, [1]=Y, [2]=program

  typedef enum logic [1:0] {
    SP_NONE = 2'd0,
    SP_X    = 2'd1,
    SP_Y    = 2'd2,
    SP_P    = 2'd3
  } space_e;

  typedef enum logic {
    PH_SETUP  = 1'b0,
    PH_STROBE = 1'b1
  } phase_e;

  // fixed priority: X before Y before program
  function automatic space_e pick_next(input logic [NSPACE-1:0] pend);
    if (pend[0])      return SP_X;
    else if (pend[1]) return SP_Y;
    else if (pend[2]) return SP_P;
    else              return SP_NONE;
  endfunction

  function automatic logic [NSPACE-1:0] space_bit(input space_e s);
    case (s)
      SP_X:    return 3'b001;
      SP_Y:    return 3'b010;
      SP_P:    return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/xmem_req_store.sv
module xmem_req_store
  import xmem_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 24,
  parameter int VEC_WORDS = 128
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      accept,
  input  logic [NSPACE-1:0]         req,
  input  logic [NSPACE-1:0]         we_in,
  input  logic [NSPACE-1:0][AW-1:0] addr_in,
  input  logic [NSPACE-1:0][DW-1:0] wdata_in,
  input  logic                      dev_mode,
  input  space_e                    cur,
  output logic [AW-1:0]             cur_addr,
  output logic                      cur_we,
  output logic [DW-1:0]             cur_wdata,
  output logic                      cur_vec
);

  localparam logic [AW-1:0] VEC_LIM = AW'(VEC_WORDS);

  logic [NSPACE-1:0][AW-1:0] addr_q;
  logic [NSPACE-1:0][DW-1:0] wdata_q;
  logic [NSPACE-1:0]         we_q;
  logic                      vec_q;
  logic                      vec_d;

  for (genvar i = 0; i < NSPACE; i++) begin : g_slot
    logic en;
    assign en = accept & req[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[i]  <= '0;
        wdata_q[i] <= '0;
        we_q[i]    <= 1'b0;
      end else if (en) begin
        addr_q[i]  <= addr_in[i];
        wdata_q[i] <= wdata_in[i];
        we_q[i]    <= we_in[i];
      end
    end
  end

  assign vec_d = dev_mode & (addr_in[2] < VEC_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 vec_q <= 1'b0;
    else if (accept && req[2])  vec_q <= vec_d;
  end

  always_comb begin
    cur_addr  = '0;
    cur_we    = 1'b0;
    cur_wdata = '0;
    cur_vec   = 1'b0;
    case (cur)
      SP_X: begin cur_addr = addr_q[0]; cur_we = we_q[0]; cur_wdata = wdata_q[0]; end
      SP_Y: begin cur_addr = addr_q[1]; cur_we = we_q[1]; cur_wdata = wdata_q[1]; end
      SP_P: begin cur_addr = addr_q[2]; cur_vec = vec_q; end
      default: ;
    endcase
  end

endmodule

// File: rtl/xmem_slot_seq.sv
module xmem_slot_seq
  import xmem_pkg::*;
#(
  parameter int WSW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [NSPACE-1:0] req,
  input  logic [WSW-1:0]    ws_x,
  input  logic [WSW-1:0]    ws_y,
  input  logic [WSW-1:0]    ws_p,
  output logic              busy,
  output phase_e            phase,
  output space_e            cur,
  output logic              slot_done
);

  logic [NSPACE-1:0] pend_q, pend_d, pend_left;
  space_e            cur_q, cur_d;
  phase_e            phase_q, phase_d;
  logic              busy_q, busy_d;
  logic [WSW-1:0]    wcnt_q, wcnt_d;
  logic [WSW-1:0]    ws_sel;
  logic              adv;

  always_comb begin
    case (cur_q)
      SP_X:    ws_sel = ws_x;
      SP_Y:    ws_sel = ws_y;
      SP_P:    ws_sel = ws_p;
      default: ws_sel = '0;
    endcase
  end

  assign pend_left = pend_q & ~space_bit(cur_q);

  // next-state process
  always_comb begin
    pend_d    = pend_q;
    cur_d     = cur_q;
    phase_d   = phase_q;
    busy_d    = busy_q;
    wcnt_d    = wcnt_q;
    slot_done = 1'b0;
    if (!busy_q) begin
      if (accept && (|req)) begin
        pend_d  = req;
        cur_d   = pick_next(req);
        phase_d = PH_SETUP;
        busy_d  = 1'b1;
      end
    end else if (phase_q == PH_SETUP) begin
      phase_d = PH_STROBE;
      wcnt_d  = ws_sel;
    end else if (wcnt_q != '0) begin
      wcnt_d = wcnt_q - 1'b1;
    end else begin
      slot_done = 1'b1;
      pend_d    = pend_left;
      if (|pend_left) begin
        cur_d   = pick_next(pend_left);
        phase_d = PH_SETUP;
      end else begin
        busy_d  = 1'b0;
      end
    end
  end

  assign adv = busy_q | accept;

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      cur_q   <= SP_NONE;
      phase_q <= PH_SETUP;
      busy_q  <= 1'b0;
      wcnt_q  <= '0;
    end else if (adv) begin
      pend_q  <= pend_d;
      cur_q   <= cur_d;
      phase_q <= phase_d;
      busy_q  <= busy_d;
      wcnt_q  <= wcnt_d;
    end
  end

  assign busy  = busy_q;
  assign phase = phase_q;
  assign cur   = cur_q;

  // R2: within a set the served space only moves toward lower priority
  assert_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && (cur_q != $past(cur_q))) |-> (cur_q > $past(cur_q)));

  // R6: while wait states remain, the same strobe continues
  assert_wait_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && phase_q == PH_STROBE && wcnt_q != '0) |=> (busy_q && phase_q == PH_STROBE && $stable(cur_q)));

  // R5: a setup cycle always leads into a strobe
  assert_setup_then_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && phase_q == PH_SETUP) |=> (busy_q && phase_q == PH_STROBE));

endmodule

// File: rtl/xmem_rdata_cap.sv
module xmem_rdata_cap
  import xmem_pkg::*;
#(
  parameter int DW = 24
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      slot_done,
  input  logic                      cur_we,
  input  space_e                    cur,
  input  logic [DW-1:0]             din,
  output logic [NSPACE-1:0][DW-1:0] rdata
);

  for (genvar i = 0; i < NSPACE; i++) begin : g_cap
    logic en;
    assign en = slot_done & ~cur_we & (cur == space_e'(2'(i + 1)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata[i] <= '0;
      else if (en) rdata[i] <= din;
    end
  end

endmodule

// File: rtl/xmem_access_seq.sv
module xmem_access_seq
  import xmem_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 24,
  parameter int WSW       = 4,
  parameter int VEC_WORDS = 128
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_load,
  input  logic           x_req,
  input  logic           x_we,
  input  logic [AW-1:0]  x_addr,
  input  logic [DW-1:0]  x_wdata,
  input  logic           y_req,
  input  logic           y_we,
  input  logic [AW-1:0]  y_addr,
  input  logic [DW-1:0]  y_wdata,
  input  logic           p_req,
  input  logic [AW-1:0]  p_addr,
  input  logic           dev_mode,
  input  logic [WSW-1:0] ws_x,
  input  logic [WSW-1:0] ws_y,
  input  logic [WSW-1:0] ws_p,
  input  logic [DW-1:0]  ext_din,
  output logic           stall,
  output logic [AW-1:0]  ext_addr,
  output logic [DW-1:0]  ext_dout,
  output logic           ext_doe,
  output logic           rd_n,
  output logic           wr_n,
  output logic           ps_n,
  output logic           ds_n,
  output logic           xy_sel,
  output logic [DW-1:0]  x_rdata,
  output logic [DW-1:0]  y_rdata,
  output logic [DW-1:0]  p_rdata
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  logic                      busy, slot_done, accept;
  phase_e                    phase;
  space_e                    cur;
  logic [AW-1:0]             cur_addr;
  logic                      cur_we, cur_vec;
  logic [DW-1:0]             cur_wdata;
  logic [NSPACE-1:0][DW-1:0] rdata;
  logic                      strobe_on;

  assign accept = req_load & ~busy;

  xmem_slot_seq #(.WSW(WSW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .accept    (accept),
    .req       ({p_req, y_req, x_req}),
    .ws_x      (ws_x),
    .ws_y      (ws_y),
    .ws_p      (ws_p),
    .busy      (busy),
    .phase     (phase),
    .cur       (cur),
    .slot_done (slot_done)
  );

  xmem_req_store #(.AW(AW), .DW(DW), .VEC_WORDS(VEC_WORDS)) u_store (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .accept    (accept),
    .req       ({p_req, y_req, x_req}),
    .we_in     ({1'b0, y_we, x_we}),
    .addr_in   ({p_addr, y_addr, x_addr}),
    .wdata_in  ({DW'(0), y_wdata, x_wdata}),
    .dev_mode  (dev_mode),
    .cur       (cur),
    .cur_addr  (cur_addr),
    .cur_we    (cur_we),
    .cur_wdata (cur_wdata),
    .cur_vec   (cur_vec)
  );

  xmem_rdata_cap #(.DW(DW)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .slot_done (slot_done),
    .cur_we    (cur_we),
    .cur       (cur),
    .din       (ext_din),
    .rdata     (rdata)
  );

  assign strobe_on = busy & (phase == PH_STROBE);
  assign stall     = busy;
  assign ext_addr  = cur_addr;
  assign ext_dout  = cur_wdata;
  assign ext_doe   = strobe_on & cur_we;
  assign rd_n      = ~(strobe_on & ~cur_we);
  assign wr_n      = ~(strobe_on & cur_we);
  assign ps_n      = (cur != SP_P);
  assign ds_n      = ~((cur == SP_X) | (cur == SP_Y));
  assign xy_sel    = (cur == SP_Y) ? 1'b0 : ((cur == SP_P) ? ~cur_vec : 1'b1);
  assign x_rdata   = rdata[0];
  assign y_rdata   = rdata[1];
  assign p_rdata   = rdata[2];

  // R5: strobes mutually exclusive
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(!rd_n && !wr_n));

  // R5: a strobe starts only after a cycle with both strobes inactive
  assert_strobe_guard_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($fell(rd_n) || $fell(wr_n)) |-> $past(rd_n && wr_n));

  // R3: space selects never active together
  assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({~ps_n, ~ds_n}));

  // R7: bus address and selects frozen while idle
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!stall && $past(!stall)) |-> ($stable(ext_addr) && $stable({ps_n, ds_n, xy_sel})));

endmodule

// File: tb/xmem_access_seq_tb.sv
module xmem_access_seq_tb;

  logic        clk, rst_n, req_load;
  logic        x_req, x_we, y_req, y_we, p_req, dev_mode;
  logic [15:0] x_addr, y_addr, p_addr;
  logic [23:0] x_wdata, y_wdata;
  logic [3:0]  ws_x, ws_y, ws_p;
  logic [23:0] ext_din;
  logic        stall, ext_doe, rd_n, wr_n, ps_n, ds_n, xy_sel;
  logic [15:0] ext_addr;
  logic [23:0] ext_dout, x_rdata, y_rdata, p_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // recorded bus events
  int          ev_sp  [0:3];
  int          ev_len [0:3];
  logic [15:0] ev_addr[0:3];
  logic        ev_xy  [0:3];
  logic [23:0] ev_wd  [0:3];
  logic        ev_doe [0:3];
  int          evn, stall_cnt, excl_bad, guard_bad, sel_bad;

  xmem_access_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_load(req_load),
    .x_req(x_req), .x_we(x_we), .x_addr(x_addr), .x_wdata(x_wdata),
    .y_req(y_req), .y_we(y_we), .y_addr(y_addr), .y_wdata(y_wdata),
    .p_req(p_req), .p_addr(p_addr), .dev_mode(dev_mode),
    .ws_x(ws_x), .ws_y(ws_y), .ws_p(ws_p), .ext_din(ext_din),
    .stall(stall), .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_doe(ext_doe),
    .rd_n(rd_n), .wr_n(wr_n), .ps_n(ps_n), .ds_n(ds_n), .xy_sel(xy_sel),
    .x_rdata(x_rdata), .y_rdata(y_rdata), .p_rdata(p_rdata)
  );

  // external memory model: data derived from the address
  assign ext_din = {~ext_addr[7:0], ext_addr};

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic int decode_space();
    if (!ps_n)          return 3;
    if (!ds_n && xy_sel) return 1;
    if (!ds_n)          return 2;
    return 0;
  endfunction

  task automatic run_set(input logic rx, ry, rp, wx, wy,
                         input logic [15:0] ax, ay, ap,
                         input logic [23:0] dx, dy,
                         input logic [3:0] wsx, wsy, wsp, input logic dev);
    logic prev_on, prev_rd, on;
    @(negedge clk);
    x_req = rx; y_req = ry; p_req = rp; x_we = wx; y_we = wy;
    x_addr = ax; y_addr = ay; p_addr = ap; x_wdata = dx; y_wdata = dy;
    ws_x = wsx; ws_y = wsy; ws_p = wsp; dev_mode = dev; req_load = 1'b1;
    @(negedge clk);
    req_load = 1'b0; x_req = 0; y_req = 0; p_req = 0;
    evn = 0; stall_cnt = 0; excl_bad = 0; guard_bad = 0; sel_bad = 0;
    prev_on = 0; prev_rd = 1;
    while (stall === 1'b1 && stall_cnt < 300) begin
      stall_cnt++;
      on = !rd_n || !wr_n;
      if (!rd_n && !wr_n) excl_bad++;
      if (!ps_n && !ds_n) sel_bad++;
      if (on && prev_on && (rd_n != prev_rd)) guard_bad++;
      if (on && !prev_on) begin
        if (evn < 4) begin
          ev_sp[evn] = decode_space(); ev_addr[evn] = ext_addr; ev_xy[evn] = xy_sel;
          ev_len[evn] = 0; ev_wd[evn] = 24'h0; ev_doe[evn] = 1'b0;
        end
        evn++;
      end
      if (on && evn > 0 && evn <= 4) begin
        ev_len[evn-1]++;
        if (!wr_n) begin ev_wd[evn-1] = ext_dout; ev_doe[evn-1] = ext_doe; end
      end
      prev_on = on; prev_rd = rd_n;
      @(negedge clk);
    end
  endtask

  task automatic check_common(input string tag);
    chk(excl_bad == 0, {tag, " R5 strobes overlap"}, excl_bad, 0);
    chk(guard_bad == 0, {tag, " R5 no guard between read and write"}, guard_bad, 0);
    chk(sel_bad == 0, {tag, " R3 both selects active"}, sel_bad, 0);
  endtask

  task automatic t_reset();
    chk(stall == 1'b0, "R9 reset stall", stall, 0);
    chk(rd_n && wr_n, "R9 reset strobes", {rd_n, wr_n}, 2'b11);
    chk(ps_n && ds_n, "R9 reset selects", {ps_n, ds_n}, 2'b11);
    chk(ext_doe == 1'b0, "R9 reset doe", ext_doe, 0);
  endtask

  task automatic t_three_reads();
    run_set(1, 1, 1, 0, 0, 16'h0100, 16'h0200, 16'h0300, 0, 0, 4'd0, 4'd1, 4'd2, 0);
    chk(stall_cnt == 9, "R1 stall cycles three reads", stall_cnt, 9);
    chk(evn == 3, "R2 slot count", evn, 3);
    chk(ev_sp[0] == 1 && ev_sp[1] == 2 && ev_sp[2] == 3, "R2 order X,Y,P",
        {ev_sp[0][3:0], ev_sp[1][3:0], ev_sp[2][3:0]}, 12'h123);
    chk(ev_xy[0] == 1 && ev_xy[1] == 0 && ev_xy[2] == 1, "R3 xy_sel per space",
        {ev_xy[0], ev_xy[1], ev_xy[2]}, 3'b101);
    chk(ev_addr[0] == 16'h0100 && ev_addr[1] == 16'h0200 && ev_addr[2] == 16'h0300,
        "R3 address per slot", ev_addr[2], 16'h0300);
    chk(ev_len[0] == 1 && ev_len[1] == 2 && ev_len[2] == 3, "R6 strobe lengths",
        {ev_len[0][3:0], ev_len[1][3:0], ev_len[2][3:0]}, 12'h123);
    chk(x_rdata == 24'hFF0100, "R8 x read data", x_rdata, 24'hFF0100);
    chk(y_rdata == 24'hFF0200, "R8 y read data", y_rdata, 24'hFF0200);
    chk(p_rdata == 24'hFF0300, "R8 p read data", p_rdata, 24'hFF0300);
    check_common("three reads");
  endtask

  task automatic t_xy_writes();
    run_set(1, 1, 0, 1, 1, 16'h0010, 16'h0010, 16'h0000, 24'hABCDEF, 24'h123456,
            4'd0, 4'd0, 4'd0, 0);
    chk(stall_cnt == 4, "R9 X+Y pair takes two slots (R1 stall)", stall_cnt, 4);
    chk(evn == 2 && ev_sp[0] == 1 && ev_sp[1] == 2, "R9 pair order", evn, 2);
    chk(ev_wd[0] == 24'hABCDEF && ev_doe[0], "R8 x write data", ev_wd[0], 24'hABCDEF);
    chk(ev_wd[1] == 24'h123456 && ev_doe[1], "R8 y write data", ev_wd[1], 24'h123456);
    chk(x_rdata == 24'hFF0100, "R8 write leaves x result", x_rdata, 24'hFF0100);
    check_common("xy writes");
  endtask

  task automatic t_mixed();
    run_set(1, 1, 1, 0, 1, 16'h0400, 16'h0500, 16'h0600, 0, 24'h00C0DE,
            4'd3, 4'd0, 4'd15, 0);
    chk(stall_cnt == 24, "R1 stall cycles mixed", stall_cnt, 24);
    chk(ev_len[0] == 4 && ev_len[1] == 1 && ev_len[2] == 16, "R6 mixed lengths",
        ev_len[2], 16);
    chk(ev_wd[1] == 24'h00C0DE, "R8 y write between reads", ev_wd[1], 24'h00C0DE);
    chk(p_rdata == 24'hFF0600, "R8 p read after write", p_rdata, 24'hFF0600);
    check_common("mixed");
  endtask

  task automatic t_vector();
    run_set(0, 0, 1, 0, 0, 0, 0, 16'h0200, 0, 0, 4'd0, 4'd0, 4'd0, 1);
    chk(ev_sp[0] == 3 && ev_xy[0] == 1, "R4 dev non-vector fetch xy high", ev_xy[0], 1);
    chk(stall_cnt == 2, "R1 single fetch stall", stall_cnt, 2);
    run_set(0, 0, 1, 0, 0, 0, 0, 16'h0004, 0, 0, 4'd0, 4'd0, 4'd0, 0);
    chk(ev_xy[0] == 1, "R4 vector fetch outside dev mode xy high", ev_xy[0], 1);
    run_set(0, 0, 1, 0, 0, 0, 0, 16'h0004, 0, 0, 4'd0, 4'd0, 4'd0, 1);
    chk(ev_xy[0] == 0 && ev_sp[0] == 3, "R4 dev vector fetch xy low", ev_xy[0], 0);
  endtask

  task automatic t_idle_hold();
    logic [15:0] a0;
    logic [2:0]  s0;
    int          bad;
    a0 = ext_addr; s0 = {ps_n, ds_n, xy_sel};
    bad = 0;
    @(negedge clk);
    x_addr = 16'hFFFF; y_addr = 16'hEEEE; p_addr = 16'hDDDD; dev_mode = 0;
    req_load = 1'b1;          // load with no request flags
    @(negedge clk);
    req_load = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (stall !== 1'b0) bad++;
      if (ext_addr !== a0 || {ps_n, ds_n, xy_sel} !== s0) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R7 idle address/selects hold, R1 empty load no stall", bad, 0);
    chk(ext_addr == 16'h0004, "R7 held address", ext_addr, 16'h0004);
  endtask

  initial begin
    rst_n = 0; req_load = 0; x_req = 0; y_req = 0; p_req = 0; x_we = 0; y_we = 0;
    x_addr = 0; y_addr = 0; p_addr = 0; x_wdata = 0; y_wdata = 0;
    ws_x = 0; ws_y = 0; ws_p = 0; dev_mode = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_three_reads();
    t_xy_writes();
    t_mixed();
    t_vector();
    t_idle_hold();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule